// File: doc/BRIEF.md
# Earliest-Deadline Crossbar Cell Scheduler

This block is the central scheduler of an input-queued switch that moves fixed-size cells through a non-blocking crossbar. In each cell-time, every input port offers one request per output, made of a valid bit and an unsigned deadline. The block turns these requests into a conflict-free matching. No input sends more than one cell and no output receives more than one cell.

Matching is greedy. Each pass takes the single earliest deadline among requests whose input and output are both still free, and grants it. That input and that output then drop out of later passes. Deadlines are compared modulo 2^DW, and equal deadlines are settled by the lower input index first and then the lower output index. A per-output enable mask excludes outputs that cannot accept a cell in this cell-time.

A pulse on `start` begins a run, and `done` pulses a fixed number of cycles later. The result appears in two forms. One is a grant map indexed by input, which the input buffers read. The other is a select map indexed by output, which drives the crossbar. Both maps hold until the next run starts.

Top module: `edf_xbar_arb`

## Requirements
- R1: While reset is asserted and after it, before any run, `busy`, `done`, every `gnt_vld` bit and every `sel_vld` bit are 0.
- R2: A `start` sampled while idle raises `busy` on the next edge. `done` is a one-cycle pulse, driven exactly N clock edges after that `start` edge, and `busy` falls together with it.
- R3: Every input holds at most one grant and every output at most one selection. If input i is granted output o (field i of `gnt_out`, IW bits at bit i*IW), then `sel_vld[o]` is 1 and field o of `sel_in` equals i, and the reverse also holds.
- R4: The matching equals the greedy result: repeatedly grant the earliest eligible deadline, then retire its input and its output. The request from input i to output o is bit i*N+o of `req_vld`, and its deadline is the DW bits at (i*N+o)*DW of `req_dl`.
- R5: Deadline a is earlier than b when (a-b) mod 2^DW is 2^(DW-1) or more. For example, 16'hFFF0 is earlier than 16'h0010.
- R6: Among equal deadlines, the lower input index wins, and after that the lower output index. With all requests valid and all deadlines equal, input i is granted output i.
- R7: A request whose `req_vld` bit is 0, or whose output has its `out_en` bit at 0, is never granted. When nothing is eligible, the run ends with no grants at the normal time.
- R8: A `start` sampled while `busy` is 1 is ignored. The current run ends at its original time and no extra `done` follows.
- R9: After `done`, both maps hold their values whatever the request inputs do, until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a matching run (accepted only while idle) |
| req_vld | input | N*N | Request valid, bit i*N+o for input i to output o |
| req_dl | input | N*N*DW | Request deadlines, field i*N+o |
| out_en | input | N | Per-output enable; 0 marks the output busy |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the maps are final |
| gnt_vld | output | N | Input i has a grant |
| gnt_out | output | N*IW | Granted output index per input |
| sel_vld | output | N | Output o is driven this cell-time |
| sel_in | output | N*IW | Crossbar select: source input per output |

## Verification
Every result is tied to the edge that accepted `start`. `busy` is due one edge later, and `done` together with both maps is due exactly N edges later. The bench reads its cycle counter at the falling edge after it pulses `start` and stores the due cycle with each expected matching in the scoreboard. The monitor samples on falling edges only and fails a check if `done` comes early, comes late, or comes with no matching pending. The ignored-start and hold cases are checked by counting `done` pulses and re-reading the maps over a further N+4 cycles after the run.

// File: rtl/edf_arb_pkg.sv
package edf_arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } arb_state_e;
endpackage

// File: rtl/edf_min_tree.sv
// Reduction tree returning the index of the earliest eligible deadline.
// Index order is input-major, so keeping the left operand on a tie
// gives lower input first, then lower output.
module edf_min_tree #(
  parameter int M   = 1024,
  parameter int DW  = 16,
  parameter int IXW = $clog2(M)
) (
  input  logic [M-1:0]    elig,
  input  logic [M*DW-1:0] dl,
  output logic            found,
  output logic [IXW-1:0]  win_ix
);
  localparam int LV = $clog2(M);

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int W = M >> l;
    logic [W-1:0]   v;
    logic [IXW-1:0] ix [W];
    if (l == 0) begin : g_leaf
      logic [DW-1:0] d [W];
      for (genvar k = 0; k < W; k++) begin : g_k
        assign v[k]  = elig[k];
        assign d[k]  = dl[k*DW +: DW];
        assign ix[k] = IXW'(k);
      end
    end else if (l < LV) begin : g_node
      logic [DW-1:0] d [W];
      for (genvar k = 0; k < W; k++) begin : g_k
        logic [DW-1:0] diff;
        logic          take_r;
        assign diff   = g_lv[l-1].g_sub.d[2*k+1] - g_lv[l-1].g_sub.d[2*k];
        assign take_r = g_lv[l-1].v[2*k+1] &
                        (~g_lv[l-1].v[2*k] | diff[DW-1]);
        assign v[k]   = g_lv[l-1].v[2*k] | g_lv[l-1].v[2*k+1];
        assign d[k]   = take_r ? g_lv[l-1].g_sub.d[2*k+1] : g_lv[l-1].g_sub.d[2*k];
        assign ix[k]  = take_r ? g_lv[l-1].ix[2*k+1] : g_lv[l-1].ix[2*k];
      end
    end else begin : g_root
      logic [DW-1:0] diff;
      logic          take_r;
      assign diff   = g_lv[l-1].g_sub.d[1] - g_lv[l-1].g_sub.d[0];
      assign take_r = g_lv[l-1].v[1] & (~g_lv[l-1].v[0] | diff[DW-1]);
      assign v[0]   = g_lv[l-1].v[0] | g_lv[l-1].v[1];
      assign ix[0]  = take_r ? g_lv[l-1].ix[1] : g_lv[l-1].ix[0];
    end
    // uniform handle on the deadline array of non-root levels
    if (l < LV) begin : g_sub
      logic [DW-1:0] d [W];
      for (genvar k = 0; k < W; k++) begin : g_cp
        if (l == 0) begin : g_a
          assign d[k] = g_lv[l].g_leaf.d[k];
        end else begin : g_b
          assign d[k] = g_lv[l].g_node.d[k];
        end
      end
    end
  end

  assign found  = g_lv[LV].v[0];
  assign win_ix = g_lv[LV].ix[0];
endmodule

// File: rtl/edf_arb_ctrl.sv
// Run sequencer: fixed N passes per accepted start.
module edf_arb_ctrl
  import edf_arb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic clr,
  output logic pass_en
);
  localparam int CW = $clog2(N) + 1;

  arb_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    clr     = 1'b0;
    pass_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n  = ST_RUN;
          cnt_n = '0;
          clr   = 1'b1;
        end
      end
      ST_RUN: begin
        pass_en = 1'b1;
        if (cnt_q == CW'(N - 1)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      st_q <= st_n;
      done <= done_n;
      if (clr || pass_en) cnt_q <= cnt_n;
    end
  end

  assign busy = (st_q == ST_RUN);
endmodule

// File: rtl/edf_grant_map.sv
// Holds the input-indexed grant map and output-indexed select map.
module edf_grant_map #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [IW-1:0] upd_in,
  input  logic [IW-1:0] upd_out,
  output logic [N-1:0]    gnt_vld,
  output logic [N*IW-1:0] gnt_out,
  output logic [N-1:0]    sel_vld,
  output logic [N*IW-1:0] sel_in
);
  logic [N-1:0]    gv_n, sv_n;
  logic [N*IW-1:0] go_n, si_n;

  always_comb begin
    gv_n = gnt_vld;
    go_n = gnt_out;
    sv_n = sel_vld;
    si_n = sel_in;
    if (clr) begin
      gv_n = '0;
      go_n = '0;
      sv_n = '0;
      si_n = '0;
    end else if (upd) begin
      gv_n[upd_in]              = 1'b1;
      go_n[upd_in*IW +: IW]     = upd_out;
      sv_n[upd_out]             = 1'b1;
      si_n[upd_out*IW +: IW]    = upd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld <= '0;
      gnt_out <= '0;
      sel_vld <= '0;
      sel_in  <= '0;
    end else if (clr || upd) begin
      gnt_vld <= gv_n;
      gnt_out <= go_n;
      sel_vld <= sv_n;
      sel_in  <= si_n;
    end
  end
endmodule

// File: rtl/edf_xbar_arb.sv
module edf_xbar_arb #(
  parameter int N  = 32,
  parameter int DW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N-1:0]    req_vld,
  input  logic [N*N*DW-1:0] req_dl,
  input  logic [N-1:0]      out_en,
  output logic              busy,
  output logic              done,
  output logic [N-1:0]      gnt_vld,
  output logic [N*IW-1:0]   gnt_out,
  output logic [N-1:0]      sel_vld,
  output logic [N*IW-1:0]   sel_in
);
  localparam int M   = N * N;
  localparam int IXW = $clog2(M);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  logic           clr, pass_en, found, upd;
  logic [M-1:0]   elig;
  logic [IXW-1:0] win_ix;

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar o = 0; o < N; o++) begin : g_out
      assign elig[i*N+o] = req_vld[i*N+o] & out_en[o] & ~gnt_vld[i] & ~sel_vld[o];
    end
  end

  edf_arb_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .clr     (clr),
    .pass_en (pass_en)
  );

  edf_min_tree #(.M(M), .DW(DW), .IXW(IXW)) u_tree (
    .elig   (elig),
    .dl     (req_dl),
    .found  (found),
    .win_ix (win_ix)
  );

  assign upd = pass_en & found;

  edf_grant_map #(.N(N), .IW(IW)) u_map (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (clr),
    .upd     (upd),
    .upd_in  (win_ix[IXW-1 -: IW]),
    .upd_out (win_ix[IW-1:0]),
    .gnt_vld (gnt_vld),
    .gnt_out (gnt_out),
    .sel_vld (sel_vld),
    .sel_in  (sel_in)
  );
endmodule

// File: rtl/edf_xbar_arb_chk.sv
module edf_xbar_arb_chk #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [N-1:0]    out_en,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    gnt_vld,
  input logic [N*IW-1:0] gnt_out,
  input logic [N-1:0]    sel_vld,
  input logic [N*IW-1:0] sel_in
);
  localparam int LW = $clog2(N) + 2;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy)           lat_q <= lat_q + 1'b1;
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(N) && !busy));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_count_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_vld) == $countones(sel_vld));
  p_en_respect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((sel_vld & ~out_en) == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(gnt_vld) && $stable(gnt_out) &&
                           $stable(sel_vld) && $stable(sel_in)));

  for (genvar i = 0; i < N; i++) begin : g_x
    p_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[i] |-> (sel_vld[gnt_out[i*IW +: IW]] &&
                      sel_in[gnt_out[i*IW +: IW]*IW +: IW] == IW'(i)));
  end
endmodule

bind edf_xbar_arb edf_xbar_arb_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .start   (start),
  .out_en  (out_en),
  .busy    (busy),
  .done    (done),
  .gnt_vld (gnt_vld),
  .gnt_out (gnt_out),
  .sel_vld (sel_vld),
  .sel_in  (sel_in)
);

// File: tb/edf_xbar_arb_tb.sv
module edf_xbar_arb_tb;
  localparam int N  = 32;
  localparam int DW = 16;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic [N-1:0]    v;
    logic [N*IW-1:0] o;
    logic [31:0]     due;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*N-1:0]    req_vld = '0;
  logic [N*N*DW-1:0] req_dl = '0;
  logic [N-1:0]      out_en = '1;
  logic              busy, done;
  logic [N-1:0]      gnt_vld, sel_vld;
  logic [N*IW-1:0]   gnt_out, sel_in;

  int   n_tests = 0, n_fail = 0, n_done = 0;
  int   cyc = 0;
  bit   mon_on = 1'b0, finished = 1'b0;
  exp_t q[$];
  string qtag[$];
  exp_t last;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edf_xbar_arb #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_vld(req_vld),
    .req_dl(req_dl), .out_en(out_en), .busy(busy), .done(done),
    .gnt_vld(gnt_vld), .gnt_out(gnt_out), .sel_vld(sel_vld), .sel_in(sel_in)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // a earlier than b under modulo-2^DW ordering (R5)
  function automatic bit earlier(input int unsigned a, input int unsigned b);
    return ((a + 65536 - b) % 65536) >= 32768;
  endfunction

  function automatic exp_t model();
    exp_t e;
    bit ib[N], ob[N];
    e = '0;
    foreach (ib[k]) begin ib[k] = 0; ob[k] = 0; end
    for (int p = 0; p < N; p++) begin
      int bi = -1, bo = -1;
      int unsigned bd = 0;
      for (int i = 0; i < N; i++)
        for (int o = 0; o < N; o++) begin
          int unsigned d = req_dl[(i*N+o)*DW +: DW];
          if (req_vld[i*N+o] && out_en[o] && !ib[i] && !ob[o] &&
              (bi < 0 || earlier(d, bd))) begin
            bi = i; bo = o; bd = d;
          end
        end
      if (bi >= 0) begin
        ib[bi] = 1; ob[bo] = 1;
        e.v[bi] = 1'b1;
        e.o[bi*IW +: IW] = IW'(bo);
      end
    end
    return e;
  endfunction

  function automatic bit maps_ok(input exp_t e, output string act);
    bit ok = 1;
    act = "";
    if (gnt_vld !== e.v) ok = 0;
    for (int i = 0; i < N; i++)
      if (e.v[i] && gnt_out[i*IW +: IW] !== e.o[i*IW +: IW]) ok = 0;
    act = $sformatf("gv=%h go=%h", gnt_vld, gnt_out);
    return ok;
  endfunction

  function automatic bit xbar_ok(input exp_t e);
    bit ok = 1;
    logic [N-1:0] sv = '0;
    for (int i = 0; i < N; i++)
      if (e.v[i]) begin
        int o = int'(e.o[i*IW +: IW]);
        sv[o] = 1'b1;
        if (sel_in[o*IW +: IW] !== IW'(i)) ok = 0;
      end
    if (sel_vld !== sv) ok = 0;
    return ok;
  endfunction

  // monitor: pops the scoreboard when done appears
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        exp_t e;
        string a;
        string t;
        n_done++;
        if (q.size() == 0) begin
          check(1'b0, "R2/R8", "done", "no done pending");
        end else begin
          e = q.pop_front();
          t = qtag.pop_front();
          check(cyc == int'(e.due), "R2",
                $sformatf("done@%0d", cyc), $sformatf("done@%0d", e.due));
          check(maps_ok(e, a), t, a, $sformatf("gv=%h go=%h", e.v, e.o));
          check(xbar_ok(e), "R3",
                $sformatf("sv=%h si=%h", sel_vld, sel_in), "select map mirrors grants");
          check(!busy, "R2", $sformatf("busy=%b", busy), "busy=0");
          last = e;
        end
      end else if (q.size() != 0 && cyc > int'(q[0].due)) begin
        check(1'b0, "R2", $sformatf("no done@%0d", cyc), $sformatf("done@%0d", q[0].due));
        void'(q.pop_front());
        void'(qtag.pop_front());
      end
    end
  end

  task automatic run(input string tag);
    exp_t e;
    e = model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e.due = 32'(cyc + N);
    q.push_back(e);
    qtag.push_back(tag);
    check(busy === 1'b1, "R2", $sformatf("busy=%b", busy), "busy=1");
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic clear_req();
    req_vld = '0;
    req_dl  = '0;
    out_en  = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: during reset
    check(busy === 0 && done === 0 && gnt_vld === '0 && sel_vld === '0, "R1",
          $sformatf("b=%b d=%b gv=%h sv=%h", busy, done, gnt_vld, sel_vld), "all 0");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 0 && done === 0 && gnt_vld === '0 && sel_vld === '0, "R1",
          $sformatf("b=%b d=%b gv=%h sv=%h", busy, done, gnt_vld, sel_vld), "all 0 after release");
    mon_on = 1'b1;

    // R4: full random request matrix, deadlines inside a narrow window
    for (int t = 0; t < 4; t++) begin
      base = $urandom_range(0, 65535);
      for (int k = 0; k < N*N; k++) begin
        req_vld[k] = ($urandom_range(0, 3) != 0);
        req_dl[k*DW +: DW] = DW'(base + $urandom_range(0, 3000));
      end
      run("R4");
    end

    // R4: sparse one-request-per-input pattern
    clear_req();
    for (int i = 0; i < N; i++) begin
      req_vld[i*N + ((i*7) % N)] = 1'b1;
      req_dl[(i*N + ((i*7) % N))*DW +: DW] = DW'(100 + 3*i);
    end
    run("R4");

    // R5: wrap-around ordering on one contended output
    clear_req();
    req_vld[0*N+0] = 1'b1; req_dl[(0*N+0)*DW +: DW] = 16'h0010;
    req_vld[1*N+0] = 1'b1; req_dl[(1*N+0)*DW +: DW] = 16'hFFF0;
    run("R5");
    check(gnt_vld[1] === 1'b1 && gnt_vld[0] === 1'b0, "R5",
          $sformatf("gv[1:0]=%b", gnt_vld[1:0]), "10");

    // R6: all valid, all equal -> diagonal
    clear_req();
    req_vld = '1;
    for (int k = 0; k < N*N; k++) req_dl[k*DW +: DW] = 16'h4242;
    run("R6");
    begin
      bit diag = 1;
      for (int i = 0; i < N; i++)
        if (!gnt_vld[i] || gnt_out[i*IW +: IW] !== IW'(i)) diag = 0;
      check(diag, "R6", $sformatf("go=%h", gnt_out), "input i -> output i");
    end

    // R6: ties on one input, lower output wins
    clear_req();
    req_vld[5*N+9] = 1'b1; req_vld[5*N+3] = 1'b1;
    req_dl[(5*N+9)*DW +: DW] = 16'd7; req_dl[(5*N+3)*DW +: DW] = 16'd7;
    run("R6");
    check(gnt_out[5*IW +: IW] === IW'(3), "R6",
          $sformatf("%0d", gnt_out[5*IW +: IW]), "3");

    // R7: disabled outputs with earliest deadlines
    clear_req();
    req_vld = '1;
    for (int k = 0; k < N*N; k++)
      req_dl[k*DW +: DW] = DW'(1000 + ((k % N) < N/2 ? 0 : 500) + (k / N));
    out_en = {N/2{2'b01}};
    run("R7");
    check((sel_vld & ~out_en) == '0, "R7", $sformatf("sv=%h", sel_vld),
          $sformatf("subset of %h", out_en));

    // R7: nothing eligible
    clear_req();
    req_vld = '1;
    out_en = '0;
    run("R7");
    check(gnt_vld === '0 && sel_vld === '0, "R7",
          $sformatf("gv=%h", gnt_vld), "0");

    // R8: second start while busy is ignored
    clear_req();
    for (int i = 0; i < N; i++) begin
      req_vld[i*N + (N-1-i)] = 1'b1;
      req_dl[(i*N + (N-1-i))*DW +: DW] = DW'(i);
    end
    begin
      exp_t e;
      int nd;
      e = model();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      e.due = 32'(cyc + N);
      q.push_back(e); qtag.push_back("R8");
      nd = n_done;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (N + 4) @(negedge clk);
      check(n_done == nd + 1, "R8", $sformatf("%0d dones", n_done - nd), "1 done");
      check(busy === 1'b0, "R8", $sformatf("busy=%b", busy), "busy=0");
    end

    // R9: maps hold while inputs change
    for (int k = 0; k < N*N; k++) begin
      req_vld[k] = $urandom_range(0, 1);
      req_dl[k*DW +: DW] = DW'($urandom_range(0, 500));
    end
    out_en = '1;
    repeat (N + 4) @(negedge clk);
    begin
      string a;
      check(maps_ok(last, a) && xbar_ok(last), "R9", a,
            $sformatf("gv=%h go=%h", last.v, last.o));
    end
    // R9: next start rebuilds from the new requests
    run("R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule